// File: doc/BRIEF.md
# Floating-Point Status and Compare Queue Register

This block keeps the 32-bit status word of a floating-point unit. Every cycle it presents the rounding mode and the denormal flush control decoded from that word. When an arithmetic operation completes, the unit reports five raw exception indications. These are packed into a 5-bit code and folded into sticky flags held in the word. If any newly reported exception has its enable bit set, the block raises a one-cycle assist trap pulse.

Compare operations leave their outcome in the same word. The relation returned by the comparator (greater, less, equal or unordered) picks one bit of a 5-bit condition mask. That bit either lands in a numbered condition position or, for target 0, becomes the current condition while the previous one is pushed into a queue of earlier results. A full-word write port lets software load the status word directly. The arithmetic itself is done elsewhere.

Top module: `fpsr_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the status word becomes 0 and `trap` becomes 0, so `round_mode` reads 0 and `flush_en` reads 0.
- R2: `round_mode` equals status bits 10:9, encoded 0 = nearest even, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity. `flush_en` equals status bit 5.
- R3: On `op_done`, the exception code is built with inexact in bit 0, underflow in bit 1, overflow in bit 2, divide-by-zero in bit 3 and invalid in bit 4. The code is ORed into status bits 31:27 at the next edge. A zero code leaves the word unchanged.
- R4: `trap` is high for exactly the cycle after an update whose new code ANDed with the pre-update status bits 4:0 is non-zero. Otherwise it is low.
- R5: A compare result is `cmp_mask[4]` for greater (`cmp_rel`=0), `cmp_mask[3]` for less (1), `cmp_mask[2]` for equal (2) and `cmp_mask[1]` for unordered (3).
- R6: For `cmp_target` y in 1..11, the result is written to status bit 22−y and no other condition bit (26 and 21:11) changes. For y of 12 or more, the condition bits are left unchanged.
- R7: For `cmp_target` 0, bits 21:12 move to bits 20:11, the old bit 26 moves into bit 21, and bit 26 takes the new result.
- R8: An unordered compare reports invalid (code bit 4) when `cmp_mask[0]` (signaling compare) or `cmp_snan` is set. Flag accumulation and trap evaluation take place in the same cycle as the condition update.
- R9: When `wr_en` is high, the status word takes `wr_data` and any coincident operation or compare update is discarded, including its trap.
- R10: When `op_done` and `cmp_done` occur in the same cycle, their exception codes are ORed and the condition update is also applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load the whole status word |
| wr_data | input | 32 | Value for the status word |
| op_done | input | 1 | An arithmetic operation completed this cycle |
| op_inexact | input | 1 | Raw inexact indication |
| op_underflow | input | 1 | Raw underflow indication |
| op_overflow | input | 1 | Raw overflow indication |
| op_divzero | input | 1 | Raw divide-by-zero indication |
| op_invalid | input | 1 | Raw invalid indication |
| cmp_done | input | 1 | A compare completed this cycle |
| cmp_rel | input | 2 | Relation: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_mask | input | 5 | Condition mask; bit 0 selects a signaling compare |
| cmp_snan | input | 1 | An operand was a signaling NaN |
| cmp_target | input | 4 | Condition target; 0 selects the queue |
| status | output | 32 | Status word |
| round_mode | output | 2 | Decoded rounding mode |
| flush_en | output | 1 | Flush denormals to zero |
| trap | output | 1 | Assist trap pulse |

## Verification
Three functions can land in the same cycle. The exception merge and the condition update both take effect at one edge when a compare reports invalid, or when `op_done` and `cmp_done` pulse together. A register write can also collide with either of them. The bench drives these coincidences on purpose, with enable bits both set and clear. It judges the resulting word and the trap pulse against an arithmetic model: flags are ORed first, the condition is placed second, and a write overrides both.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int SW          = 32;
    localparam int EXC_W       = 5;
    localparam int EXC_LSB     = 27;
    localparam int EN_LSB      = 0;
    localparam int RND_LSB     = 9;
    localparam int FLUSH_BIT   = 5;
    localparam int CUR_BIT     = 26;
    localparam int QUEUE_HI    = 21;
    localparam int QUEUE_SHIFT = 10;
    localparam int QUEUE_LO    = QUEUE_HI - QUEUE_SHIFT;
    localparam int TGT_W       = 4;
    localparam int TGT_MAX     = QUEUE_SHIFT + 1;
    localparam int MASK_W      = 5;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_POS_INF = 2'd2,
        RND_NEG_INF = 2'd3
    } rnd_mode_e;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_raw_t;

    typedef struct packed {
        rel_e              rel;
        logic [MASK_W-1:0] mask;
        logic              snan;
        logic [TGT_W-1:0]  target;
    } cmp_req_t;

    function automatic logic [EXC_W-1:0] exc_code(input exc_raw_t r);
        logic [EXC_W-1:0] c;
        c[0] = r.inexact;
        c[1] = r.underflow;
        c[2] = r.overflow;
        c[3] = r.divzero;
        c[4] = r.invalid;
        return c;
    endfunction

    function automatic logic cmp_pick(input rel_e rel, input logic [MASK_W-1:0] mask);
        logic b;
        case (rel)
            REL_GT:  b = mask[4];
            REL_LT:  b = mask[3];
            REL_EQ:  b = mask[2];
            default: b = mask[1];
        endcase
        return b;
    endfunction

    function automatic logic cmp_raises_invalid(input cmp_req_t q);
        return (q.rel == REL_UN) && (q.mask[0] || q.snan);
    endfunction

endpackage

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [1:0] rnd_field,
    input  logic       flush_field,
    output rnd_mode_e  round_mode,
    output logic       flush_en
);
    always_comb begin
        case (rnd_field)
            2'd0:    round_mode = RND_NEAREST;
            2'd1:    round_mode = RND_ZERO;
            2'd2:    round_mode = RND_POS_INF;
            default: round_mode = RND_NEG_INF;
        endcase
        flush_en = flush_field;
    end
endmodule

// File: rtl/fpsr_exc_merge.sv
module fpsr_exc_merge
    import fpsr_pkg::*;
(
    input  logic [SW-1:0]    status_in,
    input  logic             op_done,
    input  exc_raw_t         op_raw,
    input  logic             cmp_invalid,
    output logic [SW-1:0]    status_out,
    output logic             trap_req
);
    logic [EXC_W-1:0] code;

    always_comb begin
        code = op_done ? exc_code(op_raw) : '0;
        code[EXC_W-1] = code[EXC_W-1] | cmp_invalid;
        status_out = status_in;
        if (code != '0) begin
            status_out[EXC_LSB +: EXC_W] = status_in[EXC_LSB +: EXC_W] | code;
        end
        trap_req = |(code & status_in[EN_LSB +: EXC_W]);
    end
endmodule

// File: rtl/fpsr_cond_update.sv
module fpsr_cond_update
    import fpsr_pkg::*;
(
    input  logic [SW-1:0] status_in,
    input  logic          cmp_done,
    input  cmp_req_t      req,
    output logic [SW-1:0] status_out
);
    logic             result;
    logic [SW-1:0]    shifted;
    logic [SW-1:0]    targeted;

    assign result = cmp_pick(req.rel, req.mask);

    // Queued form: each queue position takes its upper neighbour.
    genvar gi;
    generate
        for (gi = 0; gi < SW; gi++) begin : g_shift
            if (gi == CUR_BIT) begin : g_cur
                assign shifted[gi] = result;
            end else if (gi == QUEUE_HI) begin : g_head
                assign shifted[gi] = status_in[CUR_BIT];
            end else if (gi >= QUEUE_LO && gi < QUEUE_HI) begin : g_body
                assign shifted[gi] = status_in[gi+1];
            end else begin : g_keep
                assign shifted[gi] = status_in[gi];
            end
        end
    endgenerate

    always_comb begin
        targeted = status_in;
        for (int y = 1; y <= TGT_MAX; y++) begin
            if (int'(req.target) == y) begin
                targeted[QUEUE_HI + 1 - y] = result;
            end
        end
    end

    always_comb begin
        if (!cmp_done) begin
            status_out = status_in;
        end else if (req.target == '0) begin
            status_out = shifted;
        end else begin
            status_out = targeted;
        end
    end
endmodule

// File: rtl/fpsr_ctl.sv
module fpsr_ctl
    import fpsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        op_done,
    input  logic        op_inexact,
    input  logic        op_underflow,
    input  logic        op_overflow,
    input  logic        op_divzero,
    input  logic        op_invalid,
    input  logic        cmp_done,
    input  logic [1:0]  cmp_rel,
    input  logic [4:0]  cmp_mask,
    input  logic        cmp_snan,
    input  logic [3:0]  cmp_target,
    output logic [31:0] status,
    output logic [1:0]  round_mode,
    output logic        flush_en,
    output logic        trap
);
    logic [SW-1:0] status_q;
    logic [SW-1:0] after_exc;
    logic [SW-1:0] after_cmp;
    logic          trap_q;
    logic          trap_req;
    logic          cmp_invalid;
    exc_raw_t      raw;
    cmp_req_t      req;
    rnd_mode_e     rmode;

    assign raw = '{invalid: op_invalid, divzero: op_divzero, overflow: op_overflow,
                   underflow: op_underflow, inexact: op_inexact};
    assign req = '{rel: rel_e'(cmp_rel), mask: cmp_mask, snan: cmp_snan, target: cmp_target};
    assign cmp_invalid = cmp_done && cmp_raises_invalid(req);

    // Flags first, then the condition placement.
    fpsr_exc_merge u_exc (
        .status_in   (status_q),
        .op_done     (op_done),
        .op_raw      (raw),
        .cmp_invalid (cmp_invalid),
        .status_out  (after_exc),
        .trap_req    (trap_req)
    );

    fpsr_cond_update u_cond (
        .status_in  (after_exc),
        .cmp_done   (cmp_done),
        .req        (req),
        .status_out (after_cmp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            trap_q   <= 1'b0;
        end else if (wr_en) begin
            status_q <= wr_data;
            trap_q   <= 1'b0;
        end else begin
            status_q <= after_cmp;
            trap_q   <= trap_req;
        end
    end

    fpsr_mode_decode u_mode (
        .rnd_field   (status_q[RND_LSB +: 2]),
        .flush_field (status_q[FLUSH_BIT]),
        .round_mode  (rmode),
        .flush_en    (flush_en)
    );

    assign round_mode = rmode;
    assign status     = status_q;
    assign trap       = trap_q;
endmodule

// File: rtl/fpsr_ctl_chk.sv
module fpsr_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        op_done,
    input logic        cmp_done,
    input logic [3:0]  cmp_target,
    input logic [31:0] status,
    input logic [1:0]  round_mode,
    input logic        flush_en,
    input logic        trap
);
    localparam logic [31:0] COND_BITS = 32'h0400_0000 | 32'h003F_F800;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (status == 32'h0) && !trap);

    a_r2_mode_follows: assert property (@(posedge clk) disable iff (rst)
        (round_mode == status[10:9]) && (flush_en == status[5]));

    a_r3_sticky_kept: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((status[31:27] & $past(status[31:27])) == $past(status[31:27])));

    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !op_done && !cmp_done) |=> $stable(status));

    a_r4_trap_cause: assert property (@(posedge clk) disable iff (rst)
        (!op_done && !cmp_done) |=> !trap);

    a_r6_single_target: assert property (@(posedge clk) disable iff (rst)
        (cmp_done && !wr_en && cmp_target != 4'd0) |=>
            ($countones((status ^ $past(status)) & COND_BITS) <= 1));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (status == $past(wr_data)) && !trap);
endmodule

bind fpsr_ctl fpsr_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .op_done    (op_done),
    .cmp_done   (cmp_done),
    .cmp_target (cmp_target),
    .status     (status),
    .round_mode (round_mode),
    .flush_en   (flush_en),
    .trap       (trap)
);

// File: tb/fpsr_ctl_tb.sv
module fpsr_ctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic        op_inexact = 1'b0, op_underflow = 1'b0, op_overflow = 1'b0;
    logic        op_divzero = 1'b0, op_invalid = 1'b0;
    logic        cmp_done = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [4:0]  cmp_mask = '0;
    logic        cmp_snan = 1'b0;
    logic [3:0]  cmp_target = '0;
    logic [31:0] status;
    logic [1:0]  round_mode;
    logic        flush_en;
    logic        trap;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model = '0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    fpsr_ctl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_inexact(op_inexact), .op_underflow(op_underflow),
        .op_overflow(op_overflow), .op_divzero(op_divzero), .op_invalid(op_invalid),
        .cmp_done(cmp_done), .cmp_rel(cmp_rel), .cmp_mask(cmp_mask),
        .cmp_snan(cmp_snan), .cmp_target(cmp_target),
        .status(status), .round_mode(round_mode), .flush_en(flush_en), .trap(trap)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Arithmetic model: returns {trap, next word}.
    function automatic logic [32:0] predict(
        input logic [31:0] s, input logic wr, input logic [31:0] wd,
        input logic opd, input logic [4:0] code, input logic cmpd,
        input logic [1:0] rel, input logic [4:0] mask, input logic snan,
        input logic [3:0] tgt);
        logic [4:0]  c;
        logic [31:0] n;
        logic        res, tp;
        if (wr) return {1'b0, wd};
        c = opd ? code : 5'd0;
        if (cmpd && rel == 2'd3 && (mask[0] || snan)) c[4] = 1'b1;
        tp = |(c & s[4:0]);
        n = s | ({27'd0, c} << 27);
        res = mask[3'd4 - {1'b0, rel}];
        if (cmpd) begin
            if (tgt == 4'd0) begin
                n[21:11] = {n[26], n[21:12]};
                n[26] = res;
            end else if (tgt <= 4'd11) begin
                n[5'd22 - {1'b0, tgt}] = res;
            end
        end
        return {tp, n};
    endfunction

    // Called just after a negative edge; checks half a cycle after the next rising edge.
    task automatic step(input string tag, input logic wr, input logic [31:0] wd,
                        input logic opd, input logic [4:0] code, input logic cmpd,
                        input logic [1:0] rel, input logic [4:0] mask,
                        input logic snan, input logic [3:0] tgt);
        logic [32:0] e;
        wr_en = wr; wr_data = wd; op_done = opd;
        {op_invalid, op_divzero, op_overflow, op_underflow, op_inexact} = code;
        cmp_done = cmpd; cmp_rel = rel; cmp_mask = mask; cmp_snan = snan; cmp_target = tgt;
        e = predict(model, wr, wd, opd, code, cmpd, rel, mask, snan, tgt);
        @(negedge clk);
        wr_en = 1'b0; op_done = 1'b0; cmp_done = 1'b0;
        model = e[31:0];
        check({tag, " status"}, status, e[31:0]);
        check({tag, " trap"}, {31'd0, trap}, {31'd0, e[32]});
    endtask

    task automatic load(input logic [31:0] v);
        step("R9 load", 1'b1, v, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 1'b0, 4'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset status", status, 32'h0);
        check("R1 reset trap", {31'd0, trap}, 32'h0);
        check("R1 reset round", {30'd0, round_mode}, 32'h0);
        check("R1 reset flush", {31'd0, flush_en}, 32'h0);

        // R2: rounding and flush decode
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 2; f++) begin
                load((32'(m) << 9) | (32'(f) << 5));
                check("R2 round_mode", {30'd0, round_mode}, 32'(m));
                check("R2 flush_en", {31'd0, flush_en}, 32'(f));
            end
        end

        // R3/R4: every code against several enable patterns
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 32; c++) begin
                logic [4:0] en;
                en = (p == 0) ? 5'h00 : (p == 1) ? 5'h1F : 5'h0A;
                load(32'h0123_4560 | {27'd0, en});
                step("R3 R4 op flags", 1'b0, '0, 1'b1, 5'(c), 1'b0, 2'd0, 5'd0, 1'b0, 4'd0);
                step("R4 trap falls", 1'b0, '0, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0, 1'b0, 4'd0);
            end
        end

        // R3: zero code leaves the word, flags stay sticky
        load(32'hA800_0003);
        step("R3 zero code", 1'b0, '0, 1'b1, 5'd0, 1'b0, 2'd0, 5'd0, 1'b0, 4'd0);
        step("R3 sticky or", 1'b0, '0, 1'b1, 5'h04, 1'b0, 2'd0, 5'd0, 1'b0, 4'd0);

        // R5/R7/R8: queued compares over every relation and mask
        load(32'h0015_5000 | 32'h1F);
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 32; k++) begin
                step("R5 R7 R8 queued cmp", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'(r), 5'(k), 1'b0, 4'd0);
            end
        end

        // R6: every target value, result 1 then 0
        for (int y = 0; y < 16; y++) begin
            load(32'h042A_A800);
            step("R6 target one", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'd2, 5'b00100, 1'b0, 4'(y));
            load(32'h003F_F800);
            step("R6 target zero", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'd0, 5'b01110, 1'b0, 4'(y));
        end

        // R8: quiet compare with signaling NaN operand, trap enabled
        load(32'h0000_0010);
        step("R8 snan quiet", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'd3, 5'b00010, 1'b1, 4'd3);
        load(32'h0000_0010);
        step("R8 quiet no snan", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'd3, 5'b00010, 1'b0, 4'd0);

        // R9: write collides with op and compare
        load(32'h0000_001F);
        step("R9 write wins", 1'b1, 32'h0000_0600, 1'b1, 5'h1F, 1'b1, 2'd3, 5'h1F, 1'b1, 4'd0);
        check("R9 round after write", {30'd0, round_mode}, 32'd3);

        // R10: op and compare together
        load(32'h0000_0001);
        step("R10 op and cmp", 1'b0, '0, 1'b1, 5'h01, 1'b1, 2'd3, 5'b00011, 1'b0, 4'd0);
        load(32'h0000_0008);
        step("R10 op and cmp tgt", 1'b0, '0, 1'b1, 5'h0A, 1'b1, 2'd1, 5'b01000, 1'b0, 4'd5);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule